// File: doc/BRIEF.md
# Shared-Counter PWM Timer

This block is a register-mapped timer that drives several edge-aligned pulse-width-modulated outputs from one shared time base. A single up-counter, clocked through a power-of-two prescaler, runs from zero up to a programmable modulo value and then wraps. Each channel compares that count with its own compare value and uses two per-channel level bits to shape its output: one level is driven when the counter reloads to zero, the other when the count reaches the compare value.

Software reaches every register through a simple word-addressed bus with an address, a write strobe, write data and combinational read data. Modulo, prescale and compare values take effect at once while the counter is stopped. While it runs they are held in a buffer and load together at the next wrap, so that a period is never cut short or stretched by a write in mid-period. Each channel also carries a match flag that software clears by writing one to it.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and every output is 0.
- R2: The global control word at 0x10 holds the prescale exponent in bits [2:0], the clock mode in bits [4:3] and a center-select bit in bit 5, and all six bits read back as written. The counter advances only when the clock mode is 01; for any other mode it holds its value. The center-select bit has no effect on counting.
- R3: With prescale exponent P the counter advances once every 2^P clocks, for P from 0 to 7.
- R4: The counter at 0x14 counts 0, 1, ... up to the active modulo value and then returns to 0, so one period lasts (modulo + 1) counter steps; a count at or above the modulo also returns to 0 on its next step.
- R5: Any write to 0x14 clears the counter to 0 and restarts the prescaler.
- R6: A write to the modulo register at 0x18 or to the prescale field takes effect at once while the counter is stopped; while it runs, the new value is held and loads at the next wrap to 0. Reading 0x18 returns the last value written.
- R7: A channel compare value (at 0x24 + 8*n) written while the counter runs is held and loads at the next wrap to 0; written while stopped it takes effect at once. Reading returns the last value written.
- R8: Channel control bits (at 0x20 + 8*n): bit 5 mode B, bit 4 mode A, bit 3 reload level, bit 2 match level. In PWM mode (mode B = 1, mode A = 0) the output takes the reload level when the counter wraps to 0 and the match level when the counter steps onto the compare value; when both happen together (compare value 0) the match level wins, and a compare value above the modulo never matches.
- R9: A channel output is 0 whenever the channel is not in PWM mode or both of its level bits are 0.
- R10: Channel control bit 7 is a flag that sets when the counter steps onto the channel compare value and clears when software writes 1 to bit 7; writing 0 there leaves it unchanged.
- R11: Channel n occupies 0x20 + 8*n (control) and 0x24 + 8*n (compare) for n below the channel count; control bits 6, 1 and 0 read 0, and any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with four channels and a 16-bit counter. Four channels are enough to give each channel its own corner at the same time (an ordinary duty, a compare value of zero, a compare value above the modulo, and inverted levels), while the slots of channels four and five fall outside the built range, so their addresses exercise the read-as-zero and ignored-write path. The 16-bit counter with small modulo values keeps several full periods, buffered reloads and the slowest prescale setting inside a short run.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PS_W   = 3;
  localparam int PRE_W  = 7;   // holds 2^PS_W - 1

  localparam logic [ADDR_W-1:0] SC_ADDR   = 8'h10;
  localparam logic [ADDR_W-1:0] CNT_ADDR  = 8'h14;
  localparam logic [ADDR_W-1:0] MOD_ADDR  = 8'h18;
  localparam int                CH_BASE   = 32;
  localparam int                CH_STRIDE = 8;
  localparam logic [1:0]        CMOD_RUN  = 2'b01;

  typedef struct packed {
    logic             center;
    logic [1:0]       cmode;
    logic [PS_W-1:0]  ps;
  } sc_t;

  typedef struct packed {
    logic msel_b;
    logic msel_a;
    logic lvl_reload;
    logic lvl_match;
  } chan_mode_t;

  function automatic logic [PRE_W-1:0] ps_limit(input logic [PS_W-1:0] ps);
    logic [PRE_W:0] span;
    span = (PRE_W+1)'(1) << ps;
    return PRE_W'(span - 1'b1);
  endfunction

  function automatic logic is_pwm(input chan_mode_t m);
    return m.msel_b & ~m.msel_a;
  endfunction

  function automatic logic drives_pin(input chan_mode_t m);
    return is_pwm(m) & (m.lvl_reload | m.lvl_match);
  endfunction

  function automatic logic [ADDR_W-1:0] ch_ctl_addr(input int n);
    return ADDR_W'(CH_BASE + CH_STRIDE * n);
  endfunction

  function automatic logic [ADDR_W-1:0] ch_cv_addr(input int n);
    return ADDR_W'(CH_BASE + CH_STRIDE * n + 4);
  endfunction
endpackage

// File: rtl/spt_timebase.sv
module spt_timebase import spt_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_nxt,
  input  logic             clr,
  input  logic [PS_W-1:0]  ps_nxt,
  input  logic [CNT_W-1:0] mod_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick,
  output logic             wrap
);
  logic [PS_W-1:0]  ps_act;
  logic [CNT_W-1:0] mod_act;
  logic [PRE_W-1:0] pre_cnt;
  logic             at_top;
  logic             load_act;

  assign at_top   = (cnt >= mod_act);
  assign tick     = run & ~clr & (pre_cnt == ps_limit(ps_act));
  assign wrap     = tick & at_top;
  assign cnt_nxt  = at_top ? '0 : cnt + 1'b1;
  // stopped, starting, or at a period boundary: active values follow the buffer
  assign load_act = ~run | ~run_nxt | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_act  <= '0;
      mod_act <= '0;
      pre_cnt <= '0;
      cnt     <= '0;
    end else begin
      if (load_act) begin
        ps_act  <= ps_nxt;
        mod_act <= mod_nxt;
      end
      if (clr | ~run | tick) pre_cnt <= '0;
      else                   pre_cnt <= pre_cnt + 1'b1;
      if (clr)       cnt <= '0;
      else if (tick) cnt <= cnt_nxt;
    end
  end

  // R4: a wrap always lands on zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  // R2: a stopped counter holds its value
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
  // R3: with a prescale above zero two steps are never back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && ps_act != '0) |=> !tick);
  // R5: a counter write clears it
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/spt_channel.sv
module spt_channel import spt_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic             run,
  input  logic             run_nxt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ctl_we,
  input  logic             cv_we,
  input  chan_mode_t       mode_wr,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cv_wr,
  output logic [7:0]       ctl_rd,
  output logic [CNT_W-1:0] cv_rd,
  output logic             pwm
);
  chan_mode_t       mode;
  logic             flag;
  logic             out_q;
  logic [CNT_W-1:0] cv_buf, cv_act, cv_buf_nxt, cv_cmp;
  logic             match;

  assign cv_buf_nxt = cv_we ? cv_wr : cv_buf;
  // at a wrap the incoming period's compare value already applies
  assign cv_cmp     = wrap ? cv_buf_nxt : cv_act;
  assign match      = tick & (cnt_nxt == cv_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      flag   <= 1'b0;
      out_q  <= 1'b0;
      cv_buf <= '0;
      cv_act <= '0;
    end else begin
      if (cv_we) cv_buf <= cv_wr;
      if (~run | ~run_nxt | wrap) cv_act <= cv_buf_nxt;
      if (ctl_we) mode <= mode_wr;
      if (match)                  flag <= 1'b1;
      else if (ctl_we & flag_clr) flag <= 1'b0;
      if (is_pwm(mode)) begin
        if (match)     out_q <= mode.lvl_match;
        else if (wrap) out_q <= mode.lvl_reload;
      end
    end
  end

  assign pwm    = drives_pin(mode) & out_q;
  assign ctl_rd = {flag, 1'b0, mode, 2'b00};
  assign cv_rd  = cv_buf;

  // R10: a match raises the flag
  a_r10_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  // R10: the flag only falls after a write-one-to-clear
  a_r10_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(ctl_we && flag_clr));
  // R8: match level follows a match in PWM mode
  a_r8_match_level: assert property (@(posedge clk) disable iff (!rst_n)
    (match && is_pwm(mode)) |=> (out_q == $past(mode.lvl_match)));
  // R8: reload level follows a wrap without a match
  a_r8_reload_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !match && is_pwm(mode)) |=> (out_q == $past(mode.lvl_reload)));
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer import spt_pkg::*; #(
  parameter int NCH   = 6,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  sc_t              sc_q, sc_nxt;
  logic             sc_we, mod_we, cnt_clr;
  logic             run, run_nxt;
  logic [CNT_W-1:0] mod_buf, mod_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             tick, wrap;
  logic [7:0]       ctl_rd [NCH];
  logic [CNT_W-1:0] cv_rd  [NCH];
  logic             wdata_unused;

  assign sc_we   = bus_we && (bus_addr == SC_ADDR);
  assign mod_we  = bus_we && (bus_addr == MOD_ADDR);
  assign cnt_clr = bus_we && (bus_addr == CNT_ADDR);
  assign sc_nxt  = sc_we  ? sc_t'(bus_wdata[5:0]) : sc_q;
  assign mod_nxt = mod_we ? bus_wdata[CNT_W-1:0] : mod_buf;
  assign run     = (sc_q.cmode == CMOD_RUN);
  assign run_nxt = (sc_nxt.cmode == CMOD_RUN);
  assign wdata_unused = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= '0;
      mod_buf <= '0;
    end else begin
      if (sc_we)  sc_q    <= sc_nxt;
      if (mod_we) mod_buf <= bus_wdata[CNT_W-1:0];
    end
  end

  spt_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .run_nxt (run_nxt),
    .clr     (cnt_clr),
    .ps_nxt  (sc_nxt.ps),
    .mod_nxt (mod_nxt),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .tick    (tick),
    .wrap    (wrap)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic ctl_we, cv_we;
    assign ctl_we = bus_we && (bus_addr == ch_ctl_addr(n));
    assign cv_we  = bus_we && (bus_addr == ch_cv_addr(n));
    spt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wrap     (wrap),
      .run      (run),
      .run_nxt  (run_nxt),
      .cnt_nxt  (cnt_nxt),
      .ctl_we   (ctl_we),
      .cv_we    (cv_we),
      .mode_wr  (bus_wdata[5:2]),
      .flag_clr (bus_wdata[7]),
      .cv_wr    (bus_wdata[CNT_W-1:0]),
      .ctl_rd   (ctl_rd[n]),
      .cv_rd    (cv_rd[n]),
      .pwm      (pwm_out[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SC_ADDR)  bus_rdata = DATA_W'(sc_q);
    if (bus_addr == CNT_ADDR) bus_rdata = DATA_W'(cnt);
    if (bus_addr == MOD_ADDR) bus_rdata = DATA_W'(mod_buf);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ch_ctl_addr(n)) bus_rdata = DATA_W'(ctl_rd[n]);
      if (bus_addr == ch_cv_addr(n))  bus_rdata = DATA_W'(cv_rd[n]);
    end
  end
endmodule

// File: tb/tb_shared_pwm_timer.sv
module tb_shared_pwm_timer;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     addr = '0;
  logic           we = 1'b0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] pwm;

  always #10 clk = ~clk;   // 50 MHz

  shared_pwm_timer #(.NCH(NCH), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
  );

  typedef struct {
    bit          is_rd;
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;

  // reference model state, updated from the requirements once per clock
  bit          m_run = 0;
  logic [5:0]  m_sc = '0;
  int          m_pc = 0;
  logic [2:0]  m_psact = '0;
  logic [15:0] m_cnt = '0, m_mact = '0, m_mpend = '0;
  logic [15:0] m_cvact [NCH];
  logic [15:0] m_cvpend[NCH];
  logic [3:0]  m_mode  [NCH];   // {mode B, mode A, reload level, match level}
  bit          m_flag  [NCH];
  bit          m_out   [NCH];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h10) r = 32'(m_sc);
    if (a == 8'h14) r = 32'(m_cnt);
    if (a == 8'h18) r = 32'(m_mpend);
    for (int n = 0; n < NCH; n++) begin
      if (a == 8'(32 + 8*n)) r = {24'b0, m_flag[n], 1'b0, m_mode[n], 2'b00};
      if (a == 8'(36 + 8*n)) r = 32'(m_cvpend[n]);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_pins();
    logic [31:0] v = '0;
    for (int n = 0; n < NCH; n++)
      v[n] = m_mode[n][3] & ~m_mode[n][2] & (m_mode[n][1] | m_mode[n][0]) & m_out[n];
    return v;
  endfunction

  task automatic m_step(input bit w, input logic [7:0] a, input logic [31:0] d);
    bit clr, run_n, tick, wrap, match;
    logic [5:0] sc_n;
    clr   = w && a == 8'h14;
    sc_n  = (w && a == 8'h10) ? d[5:0] : m_sc;
    run_n = (sc_n[4:3] == 2'b01);
    if (w && a == 8'h18) m_mpend = d[15:0];
    for (int n = 0; n < NCH; n++)
      if (w && a == 8'(36 + 8*n)) m_cvpend[n] = d[15:0];
    tick = m_run && !clr && (m_pc == (1 << m_psact) - 1);
    wrap = tick && (m_cnt >= m_mact);
    if (clr || !m_run || tick) m_pc = 0; else m_pc++;
    if (clr) m_cnt = '0;
    else if (tick) m_cnt = wrap ? 16'd0 : m_cnt + 16'd1;
    for (int n = 0; n < NCH; n++) begin
      match = tick && (m_cnt == (wrap ? m_cvpend[n] : m_cvact[n]));
      if (m_mode[n][3] && !m_mode[n][2]) begin
        if (match) m_out[n] = m_mode[n][0];
        else if (wrap) m_out[n] = m_mode[n][1];
      end
      if (match) m_flag[n] = 1;
      else if (w && a == 8'(32 + 8*n) && d[7]) m_flag[n] = 0;
      if (w && a == 8'(32 + 8*n)) m_mode[n] = d[5:2];
    end
    if (wrap || !run_n || !m_run) begin
      m_mact  = m_mpend;
      m_psact = sc_n[2:0];
      for (int n = 0; n < NCH; n++) m_cvact[n] = m_cvpend[n];
    end
    m_sc  = sc_n;
    m_run = run_n;
  endtask

  // driver: one bus cycle, pushes what the ports must show during it
  task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d, input string tag);
    item_t it;
    we = w; addr = a; wdata = d;
    it.is_rd = 0; it.a = a; it.exp = m_pins(); it.tag = tag;
    q.push_back(it);
    if (!w) begin
      it.is_rd = 1; it.exp = m_read(a);
      q.push_back(it);
    end
    @(posedge clk);
    m_step(w, a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  // monitor: compares queued expectations just before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.is_rd) begin
          if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: read addr %h got %h expected %h", it.tag, it.a, rdata, it.exp);
          end
        end else if (pwm !== it.exp[NCH-1:0]) begin
          errors++;
          $display("FAIL %s: pwm_out got %b expected %b", it.tag, pwm, it.exp[NCH-1:0]);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int n = 0; n < NCH; n++) begin
      m_cvact[n] = '0; m_cvpend[n] = '0; m_mode[n] = '0; m_flag[n] = 0; m_out[n] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and output
    cyc(0, 8'h10, 0, "R1"); cyc(0, 8'h14, 0, "R1"); cyc(0, 8'h18, 0, "R1");
    for (int n = 0; n < NCH; n++) begin
      cyc(0, 8'(32 + 8*n), 0, "R1");
      cyc(0, 8'(36 + 8*n), 0, "R1");
    end

    // R11: channel map; ch0 normal, ch1 compare 0, ch2 compare above modulo, ch3 inverted
    cyc(1, 8'h20, 32'h28, "R11"); cyc(1, 8'h28, 32'hE8, "R11");
    cyc(1, 8'h30, 32'h2B, "R11"); cyc(1, 8'h38, 32'h24, "R11");
    cyc(1, 8'h24, 4, "R11"); cyc(1, 8'h2C, 0, "R11");
    cyc(1, 8'h34, 12, "R11"); cyc(1, 8'h3C, 4, "R11");
    cyc(1, 8'h18, 9, "R6");
    for (int n = 0; n < NCH; n++) begin
      cyc(0, 8'(32 + 8*n), 0, "R11");
      cyc(0, 8'(36 + 8*n), 0, "R11");
    end
    cyc(1, 8'h40, 32'hFF, "R11"); cyc(1, 8'h44, 32'h77, "R11");
    cyc(0, 8'h40, 0, "R11"); cyc(0, 8'h44, 0, "R11"); cyc(0, 8'h12, 0, "R11");
    cyc(0, 8'h18, 0, "R6");

    // R2: start with the center-select bit set; it reads back and counting stays upward
    cyc(1, 8'h10, 32'h28, "R2"); cyc(0, 8'h10, 0, "R2");
    // R4 / R8: several periods of count and waveform
    repeat (30) cyc(0, 8'h14, 0, "R4");
    repeat (12) cyc(0, 8'h14, 0, "R8");

    // R6 / R7: modulo and compare writes while running wait for the wrap
    cyc(1, 8'h18, 5, "R6"); cyc(1, 8'h24, 2, "R7");
    cyc(0, 8'h18, 0, "R6"); cyc(0, 8'h24, 0, "R7");
    repeat (24) cyc(0, 8'h14, 0, "R7");

    // R5: counter write while running
    cyc(1, 8'h14, 32'hFFFF, "R5");
    repeat (4) cyc(0, 8'h14, 0, "R5");

    // R2: stop holds the count
    cyc(1, 8'h10, 0, "R2");
    repeat (4) cyc(0, 8'h14, 0, "R2");

    // R10: flag read, write 0 keeps it, write 1 clears it
    cyc(0, 8'h20, 0, "R10");
    cyc(1, 8'h20, 32'h28, "R10"); cyc(0, 8'h20, 0, "R10");
    cyc(1, 8'h20, 32'hA8, "R10"); cyc(0, 8'h20, 0, "R10");
    cyc(0, 8'h28, 0, "R10");

    // R9: non-PWM mode and PWM mode without levels both stay low
    cyc(1, 8'h20, 32'h08, "R9"); cyc(1, 8'h38, 32'h20, "R9");
    cyc(1, 8'h10, 32'h08, "R9");
    repeat (25) cyc(0, 8'h14, 0, "R9");

    // R3: prescale 4 started in the same write as the clock mode
    cyc(1, 8'h10, 0, "R3"); cyc(1, 8'h14, 0, "R3"); cyc(1, 8'h18, 3, "R3");
    cyc(1, 8'h10, 32'h0A, "R3");
    repeat (40) cyc(0, 8'h14, 0, "R3");

    // R6: prescale change while running waits for the wrap
    cyc(1, 8'h10, 32'h08, "R6");
    repeat (30) cyc(0, 8'h14, 0, "R6");

    // R3: slowest prescale
    cyc(1, 8'h10, 0, "R3"); cyc(1, 8'h18, 1, "R3"); cyc(1, 8'h14, 0, "R3");
    cyc(1, 8'h10, 32'h0F, "R3");
    repeat (600) cyc(0, 8'h14, 0, "R3");

    @(negedge clk);
    #8;
    finish_run();
  end
endmodule